// File: doc/BRIEF.md
# Serialized Interrupt Bus Host Sequencer

This block is the host-side master of a one-wire, open-drain interrupt bus that runs on the system bus clock. Each bus cycle begins with a Start Frame, continues with a configurable number of three-clock interrupt/data frames, and ends with a Stop Frame. In the first clock of every frame the host samples the shared line and stores the level in one bit of a status vector. The interrupt controller further down the chain reads that vector. The electrical pad and the interrupt controller are outside this block.

The width of the Stop Frame tells every agent how the next cycle starts. A two-clock stop selects quiet mode. In quiet mode the bus rests idle, and any slave may open the next cycle by pulling the line low, after which the host completes the Start Frame. A three-clock stop selects continuous mode, where only the host opens cycles and it does so as soon as the spacing rule allows. After reset the host always runs one cycle of its own, so that the default interrupt levels are collected.

The line is modelled as a pull-down enable and an active-high drive enable. Outside reset, the bus is high whenever no agent pulls it low.

Top module: `sirq_host`

## Requirements
- R1: After reset is released, the host opens a cycle on its own, whatever the mode select input says: `pull_low_o` is high in the first clock after the first rising edge with `rst_n` high.
- R2: A host-opened Start Frame holds `pull_low_o` high for `start_len_i` clocks, clamped to the range 4 to 8. This is followed by exactly one clock with `drive_high_o` high. Frame 0 begins in the next clock.
- R3: Each frame lasts three clocks (sample, recovery, turnaround), and the host does not drive during any of them. Bit i of `irq_vec_o` takes the line level (1 = high) seen at the end of the sample clock of frame i. Bits above the last frame of a cycle keep their previous value.
- R4: The number of frames per cycle is `frame_cnt_i`, clamped to the range MIN_FRAMES (17) to MAX_FRAMES. The value is taken when the Start Frame begins, so later changes to the input do not affect the running cycle.
- R5: After the turnaround clock of the last frame, the host holds `pull_low_o` high for 2 clocks if `quiet_sel_i` was 1 in that turnaround clock, or for 3 clocks if it was 0.
- R6: After a three-clock stop (continuous mode), the line is released for exactly one clock. The host's next Start Frame then begins in the following clock.
- R7: After a two-clock stop (quiet mode), the host does not drive. A low line in the first released clock after the stop is ignored. A low line seen in any later idle clock is taken as a slave-opened Start Frame: the host then pulls low for `start_len_i`−1 clocks (clamped length), so that the whole frame still has the programmed width.
- R8: While idle in quiet mode with the line high, setting `quiet_sel_i` to 0 makes the host open a Start Frame in the next clock, with the full programmed width.
- R9: While `rst_n` is low, neither `pull_low_o` nor `drive_high_o` is asserted, and `irq_vec_o` reads all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; line driven and sampled on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| sirq_line_i | input | 1 | Level of the shared interrupt line |
| quiet_sel_i | input | 1 | Mode for the next cycle: 1 quiet, 0 continuous |
| frame_cnt_i | input | clog2(MAX_FRAMES+1) | Requested frames per cycle |
| start_len_i | input | 4 | Requested Start Frame low width in clocks |
| pull_low_o | output | 1 | Pull-down enable for the line |
| drive_high_o | output | 1 | Active high drive enable (one clock after Start) |
| irq_vec_o | output | MAX_FRAMES | Captured per-frame line levels |

## Verification
The bench pushes the clamps past both ends: start widths of 3 and 9 and frame counts under 17 and above the maximum. A design that did not clamp would shorten the Start Frame or cut the cycle short. It changes the frame count in the middle of a cycle, to catch a design that re-reads the setting every frame. In quiet mode it pulls the line low during the released clock right after the stop. A host that took this glitch as a start would break the spacing rule. It also times the slave-opened Start Frame, where a host that added its full width would stretch the frame by one clock. Frame patterns of all zeros, all ones and mixed values, together with shorter cycles that follow longer ones, show whether the vector misses bits or clears the upper ones.

// File: rtl/sirq_pkg.sv
// Shared types and constants of the serialized interrupt host.
// Assumes: start width is carried in a 4-bit field.
package sirq_pkg;

    localparam int SLEN_W    = 4;
    localparam int START_MIN = 4;
    localparam int START_MAX = 8;

    typedef enum logic [2:0] {
        S_BOOT,      // first clock after reset
        S_START_LO,  // start frame, host pulling low
        S_START_HI,  // one clock of active high after start
        S_FRAME,     // interrupt/data frames
        S_STOP_LO,   // stop frame, host pulling low
        S_GAP,       // first released clock after stop
        S_IDLE       // quiet mode, waiting for any start
    } sirq_state_e;

endpackage

// File: rtl/sirq_cfg_clamp.sv
// Clamps the requested frame count and start width to their legal ranges.
// Assumes: MIN_FRAMES <= MAX_FRAMES. Purely combinational.
module sirq_cfg_clamp
    import sirq_pkg::*;
#(
    parameter int MIN_FRAMES = 17,
    parameter int MAX_FRAMES = 32,
    parameter int CNT_W      = $clog2(MAX_FRAMES + 1)
) (
    input  logic [CNT_W-1:0]  frame_cnt_i,
    input  logic [SLEN_W-1:0] start_len_i,
    output logic [CNT_W-1:0]  nfr_o,
    output logic [SLEN_W-1:0] slen_o
);

    localparam logic [CNT_W-1:0]  NF_LO = CNT_W'(MIN_FRAMES);
    localparam logic [CNT_W-1:0]  NF_HI = CNT_W'(MAX_FRAMES);
    localparam logic [SLEN_W-1:0] SL_LO = SLEN_W'(START_MIN);
    localparam logic [SLEN_W-1:0] SL_HI = SLEN_W'(START_MAX);

    // Saturate the frame count into [MIN_FRAMES, MAX_FRAMES].
    always_comb begin
        if (frame_cnt_i < NF_LO)      nfr_o = NF_LO;
        else if (frame_cnt_i > NF_HI) nfr_o = NF_HI;
        else                          nfr_o = frame_cnt_i;
    end

    // Saturate the start width into [START_MIN, START_MAX].
    always_comb begin
        if (start_len_i < SL_LO)      slen_o = SL_LO;
        else if (start_len_i > SL_HI) slen_o = SL_HI;
        else                          slen_o = start_len_i;
    end

endmodule

// File: rtl/sirq_seq.sv
// Cycle sequencer: start, frames, stop and the idle/restart policy.
// Assumes: clamped config inputs; line_i is the bus level sampled at the
// rising edge; outputs are decoded from registered state only.
module sirq_seq
    import sirq_pkg::*;
#(
    parameter int MAX_FRAMES = 32,
    parameter int CNT_W      = $clog2(MAX_FRAMES + 1),
    parameter int IDX_W      = $clog2(MAX_FRAMES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_i,
    input  logic              mode_quiet_i,
    input  logic [CNT_W-1:0]  nfr_i,
    input  logic [SLEN_W-1:0] slen_i,
    output logic              drv_low_o,
    output logic              drv_high_o,
    output logic              smp_en_o,
    output logic [IDX_W-1:0]  smp_idx_o
);

    sirq_state_e       state;
    logic [SLEN_W-1:0] cnt;
    logic [1:0]        ph;
    logic [IDX_W-1:0]  idx;
    logic [CNT_W-1:0]  nfr_q;
    logic [SLEN_W-1:0] slen_q;
    logic              quiet_cur;
    logic              slave_st;
    logic              last_frame;

    assign last_frame = (CNT_W'(idx) + CNT_W'(1)) == nfr_q;

    // Main state machine: one transition per clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= S_BOOT;
            cnt       <= '0;
            ph        <= '0;
            idx       <= '0;
            nfr_q     <= nfr_i;
            slen_q    <= SLEN_W'(START_MIN);
            quiet_cur <= 1'b0;
            slave_st  <= 1'b0;
        end else begin
            case (state)
                S_BOOT: begin
                    state    <= S_START_LO;
                    cnt      <= slen_i - SLEN_W'(1);
                    nfr_q    <= nfr_i;
                    slen_q   <= slen_i;
                    slave_st <= 1'b0;
                end
                S_START_LO: begin
                    if (cnt == '0) state <= S_START_HI;
                    else           cnt   <= cnt - SLEN_W'(1);
                end
                S_START_HI: begin
                    state <= S_FRAME;
                    ph    <= '0;
                    idx   <= '0;
                end
                S_FRAME: begin
                    if (ph == 2'd2) begin
                        ph <= '0;
                        if (last_frame) begin
                            state     <= S_STOP_LO;
                            quiet_cur <= mode_quiet_i;
                            cnt       <= mode_quiet_i ? SLEN_W'(1) : SLEN_W'(2);
                        end else begin
                            idx <= idx + IDX_W'(1);
                        end
                    end else begin
                        ph <= ph + 2'd1;
                    end
                end
                S_STOP_LO: begin
                    if (cnt == '0) state <= S_GAP;
                    else           cnt   <= cnt - SLEN_W'(1);
                end
                S_GAP: begin
                    if (quiet_cur) begin
                        state <= S_IDLE;
                    end else begin
                        state    <= S_START_LO;
                        cnt      <= slen_i - SLEN_W'(1);
                        nfr_q    <= nfr_i;
                        slen_q   <= slen_i;
                        slave_st <= 1'b0;
                    end
                end
                S_IDLE: begin
                    if (!line_i) begin
                        state    <= S_START_LO;
                        cnt      <= slen_i - SLEN_W'(2);
                        nfr_q    <= nfr_i;
                        slen_q   <= slen_i;
                        slave_st <= 1'b1;
                    end else if (!mode_quiet_i) begin
                        state    <= S_START_LO;
                        cnt      <= slen_i - SLEN_W'(1);
                        nfr_q    <= nfr_i;
                        slen_q   <= slen_i;
                        slave_st <= 1'b0;
                    end
                end
                default: state <= S_BOOT;
            endcase
        end
    end

    // Output decode from the registered state.
    assign drv_low_o  = (state == S_START_LO) || (state == S_STOP_LO);
    assign drv_high_o = (state == S_START_HI);
    assign smp_en_o   = (state == S_FRAME) && (ph == 2'd0);
    assign smp_idx_o  = idx;

    // Observation counters used only by the assertions below.
    logic [2:0]        stop_run;
    logic [SLEN_W-1:0] start_run;
    logic [CNT_W-1:0]  frm_seen;

    // Count stop clocks, start clocks and sampled frames of the cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stop_run  <= '0;
            start_run <= '0;
            frm_seen  <= '0;
        end else begin
            if (state == S_STOP_LO)      stop_run <= stop_run + 3'd1;
            else if (state == S_FRAME)   stop_run <= '0;
            if (state == S_START_LO)     start_run <= start_run + SLEN_W'(1);
            else if (state == S_START_HI) start_run <= '0;
            if (state == S_START_HI)     frm_seen <= '0;
            else if (smp_en_o)           frm_seen <= frm_seen + CNT_W'(1);
        end
    end

    AST_START_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_START_HI) |-> (start_run + {{(SLEN_W-1){1'b0}}, slave_st}) == slen_q); // R2
    AST_FRAME_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_STOP_LO) && (stop_run == 3'd0) |-> frm_seen == nfr_q); // R4
    AST_STOP_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_GAP) |-> stop_run == (quiet_cur ? 3'd2 : 3'd3)); // R5
    AST_CONT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_GAP) && !quiet_cur |=> drv_low_o); // R6
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE) |-> quiet_cur && !drv_low_o); // R7

endmodule

// File: rtl/sirq_capture.sv
// Per-frame capture register: stores the line level of each sample clock.
// Assumes: at most one sample strobe per clock; bits not sampled hold.
module sirq_capture #(
    parameter int MAX_FRAMES = 32,
    parameter int IDX_W      = $clog2(MAX_FRAMES)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  line_i,
    input  logic                  smp_en_i,
    input  logic [IDX_W-1:0]      smp_idx_i,
    output logic [MAX_FRAMES-1:0] vec_o
);

    for (genvar g = 0; g < MAX_FRAMES; g++) begin : g_bit
        logic bit_q;
        // Load this bit when its own frame is being sampled.
        always_ff @(posedge clk) begin
            if (!rst_n)                                      bit_q <= 1'b1;
            else if (smp_en_i && (smp_idx_i == IDX_W'(g)))   bit_q <= line_i;
        end
        assign vec_o[g] = bit_q;
    end

    AST_SAMPLE_STORED: assert property (@(posedge clk) disable iff (!rst_n)
        smp_en_i |=> vec_o[$past(smp_idx_i)] == $past(line_i)); // R3

endmodule

// File: rtl/sirq_host.sv
// Host controller of the serialized interrupt bus: top level.
// Assumes: the pad turns pull_low_o/drive_high_o into line levels and
// returns the resolved level on sirq_line_i.
module sirq_host
    import sirq_pkg::*;
#(
    parameter  int MIN_FRAMES = 17,
    parameter  int MAX_FRAMES = 32,
    localparam int CNT_W      = $clog2(MAX_FRAMES + 1),
    localparam int IDX_W      = $clog2(MAX_FRAMES)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  sirq_line_i,
    input  logic                  quiet_sel_i,
    input  logic [CNT_W-1:0]      frame_cnt_i,
    input  logic [3:0]            start_len_i,
    output logic                  pull_low_o,
    output logic                  drive_high_o,
    output logic [MAX_FRAMES-1:0] irq_vec_o
);

    logic [CNT_W-1:0]  nfr_c;
    logic [SLEN_W-1:0] slen_c;
    logic              smp_en;
    logic [IDX_W-1:0]  smp_idx;

    sirq_cfg_clamp #(
        .MIN_FRAMES (MIN_FRAMES),
        .MAX_FRAMES (MAX_FRAMES),
        .CNT_W      (CNT_W)
    ) u_clamp (
        .frame_cnt_i (frame_cnt_i),
        .start_len_i (start_len_i),
        .nfr_o       (nfr_c),
        .slen_o      (slen_c)
    );

    sirq_seq #(
        .MAX_FRAMES (MAX_FRAMES),
        .CNT_W      (CNT_W),
        .IDX_W      (IDX_W)
    ) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .line_i       (sirq_line_i),
        .mode_quiet_i (quiet_sel_i),
        .nfr_i        (nfr_c),
        .slen_i       (slen_c),
        .drv_low_o    (pull_low_o),
        .drv_high_o   (drive_high_o),
        .smp_en_o     (smp_en),
        .smp_idx_o    (smp_idx)
    );

    sirq_capture #(
        .MAX_FRAMES (MAX_FRAMES),
        .IDX_W      (IDX_W)
    ) u_cap (
        .clk       (clk),
        .rst_n     (rst_n),
        .line_i    (sirq_line_i),
        .smp_en_i  (smp_en),
        .smp_idx_i (smp_idx),
        .vec_o     (irq_vec_o)
    );

endmodule

// File: tb/sirq_host_bench.sv
`timescale 1ns/1ps
module sirq_host_bench;

    localparam int MAXF = 20;
    localparam int MINF = 17;
    localparam int CW   = $clog2(MAXF + 1);

    logic            clk = 1'b0;
    logic            rst_n;
    logic            slave_low;
    logic            quiet_sel;
    logic [CW-1:0]   fcnt;
    logic [3:0]      slen;
    logic            pull_low;
    logic            drv_hi;
    logic [MAXF-1:0] vec;
    logic            line;

    int n_chk  = 0;
    int n_fail = 0;
    logic [MAXF-1:0] exp_vec = '1;
    bit cur_quiet = 1'b0;

    always #2 clk = ~clk;

    assign line = !(pull_low || slave_low);

    sirq_host #(.MIN_FRAMES(MINF), .MAX_FRAMES(MAXF)) u_sirq_host (
        .clk          (clk),
        .rst_n        (rst_n),
        .sirq_line_i  (line),
        .quiet_sel_i  (quiet_sel),
        .frame_cnt_i  (fcnt),
        .start_len_i  (slen),
        .pull_low_o   (pull_low),
        .drive_high_o (drv_hi),
        .irq_vec_o    (vec)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int clamp_nfr(input int v);
        return (v < MINF) ? MINF : (v > MAXF) ? MAXF : v;
    endfunction

    function automatic int clamp_slen(input int v);
        return (v < 4) ? 4 : (v > 8) ? 8 : v;
    endfunction

    // Called at a negedge where pull_low is high: times the start frame.
    task automatic measure_start(input int exp_run, input string req);
        int run = 0;
        while (pull_low) begin
            run++;
            @(negedge clk);
        end
        chk(run == exp_run, req, run, exp_run);
        chk(drv_hi == 1'b1, "R2 high clock", int'(drv_hi), 1);
    endtask

    // Called at the negedge of the drive-high clock: runs frames and stop.
    task automatic run_frames(input int nfr, input logic [MAXF-1:0] pat, input bit next_q);
        int run = 0;
        bit drove = 1'b0;
        quiet_sel = next_q;
        fcnt = CW'(31);                  // R4: mid-cycle change must be ignored
        for (int i = 0; i < nfr; i++) begin
            slave_low = !pat[i];
            @(negedge clk);
            drove |= pull_low | drv_hi;
            @(negedge clk);
            slave_low = 1'b0;
            drove |= pull_low | drv_hi;
            @(negedge clk);
            drove |= pull_low | drv_hi;
        end
        chk(!drove, "R3 host silent in frames", int'(drove), 0);
        @(negedge clk);
        while (pull_low) begin
            run++;
            @(negedge clk);
        end
        chk(run == (next_q ? 2 : 3), "R5 stop width / R4 frame count", run, next_q ? 2 : 3);
        chk(!drv_hi, "R6 released after stop", int'(drv_hi), 0);
        for (int i = 0; i < nfr; i++) exp_vec[i] = pat[i];
        chk(vec == exp_vec, "R3 captured vector", int'(vec), int'(exp_vec));
        cur_quiet = next_q;
    endtask

    // Called at the released negedge after a stop: opens the next cycle.
    task automatic begin_next(input int k, input int sl);
        if (!cur_quiet) begin
            @(negedge clk);
            chk(pull_low, "R6 continuous restart", int'(pull_low), 1);
            measure_start(sl, "R6 start width");
        end else if (k % 2 == 0) begin
            slave_low = 1'b1;            // low in the released clock: ignored
            @(negedge clk);
            slave_low = 1'b0;
            chk(!pull_low, "R7 gap low ignored", int'(pull_low), 0);
            for (int j = 0; j < 3; j++) begin
                @(negedge clk);
                chk(!pull_low && !drv_hi, "R7 quiet idle", int'(pull_low), 0);
            end
            slave_low = 1'b1;
            @(negedge clk);
            slave_low = 1'b0;
            chk(pull_low, "R7 slave start joined", int'(pull_low), 1);
            measure_start(sl - 1, "R7 host part of slave start");
        end else begin
            for (int j = 0; j < 2; j++) begin
                @(negedge clk);
                chk(!pull_low, "R8 quiet idle", int'(pull_low), 0);
            end
            quiet_sel = 1'b0;
            @(negedge clk);
            chk(pull_low, "R8 mode switch start", int'(pull_low), 1);
            measure_start(sl, "R8 start width");
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; slave_low = 1'b0; quiet_sel = 1'b1;
        fcnt = CW'(5); slen = 4'd3;
        repeat (3) @(negedge clk);
        chk(!pull_low && !drv_hi, "R9 no drive in reset", int'(pull_low), 0);
        chk(vec == '1, "R9 vector reset", int'(vec), int'({MAXF{1'b1}}));
        rst_n = 1'b1;
        @(negedge clk);
        chk(pull_low, "R1 initial start", int'(pull_low), 1);
        measure_start(4, "R2 clamped start width");
        run_frames(clamp_nfr(5), MAXF'(32'h5A5A5), 1'b0);
        for (int k = 1; k < 15; k++) begin
            int sl_in = 3 + (k % 7);
            int fc_in = (k % 7 == 6) ? 31 : 15 + (k % 7);
            logic [MAXF-1:0] pat;
            bit nq = (k % 3 != 0);
            pat = MAXF'((k * 32'h9E3779B1) >> 5);
            if (k == 3) pat = '0;
            if (k == 4) pat = '1;
            slen = 4'(sl_in);
            fcnt = CW'(fc_in);
            begin_next(k, clamp_slen(sl_in));
            run_frames(clamp_nfr(fc_in), pat, nq);
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule